// File: doc/BRIEF.md
# Time Slot Interchanger

This block reorders the time slots of a time-division multiplexed stream. Words arrive one per slot, paced by a slot strobe. A frame-start flag marks the first slot of each frame, and a frame holds `SLOTS` slots. The block delivers the same words one frame later, moved to new slot positions under a programmable translation table. Any input slot can be routed to any output slot.

The data store has two banks. One bank collects the frame now arriving while the other plays out the frame before it, and the roles swap at every frame start. A parameter picks the memory organization:
- With `RANDOM_WRITE = 0`, arriving words are stored in slot order. The table gives, for each output slot, the input slot to read.
- With `RANDOM_WRITE = 1`, the table gives, for each input slot, the output slot its word is written to. The bank is then read in slot order.

Table writes go to a shadow copy. The shadow copy is loaded into the working table on the next frame start.

Top module: `slot_interchanger`

## Requirements
- R1: After reset `out_valid` and `out_start` are 0, and the working table maps every index to itself.
- R2: `out_valid` stays 0 until the second accepted frame start (a cycle with `slot_valid` and `frame_start` both 1). From that cycle on, output follows the input.
- R3: Once output is live, every accepted slot produces one output word on the next clock edge. That word belongs to the same slot index of the previous frame. `out_start` is 1 exactly for the word of output slot 0, which is one cycle after an accepted frame start.
- R4: With `RANDOM_WRITE = 0`, the table entry at index j names the input slot whose word of the previous frame leaves in output slot j. The table used is the one active in the frame in which the word leaves.
- R5: With `RANDOM_WRITE = 1`, the table entry at index j names the output slot that receives the word arriving in input slot j. The table used is the one active in the frame in which the word arrived.
- R6: A table write changes only the shadow copy. The working table is loaded from the shadow at each accepted frame start and holds between them. A write in the same cycle as a frame start is seen only at the following frame start.
- R7: A cycle with `slot_valid` 0 is not a slot. The slot counter holds, no word is stored, and `out_valid` is 0 on the next cycle.
- R8: A table write whose index or entry is `SLOTS` or larger is ignored.
- R9: Slot indices are 0-based. Without a frame start, the slot counter wraps from `SLOTS-1` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Slot strobe; the cycle carries one slot word |
| frame_start | input | 1 | With slot_valid, marks slot 0 of a frame |
| slot_data | input | DW | Word of the current input slot |
| tbl_we | input | 1 | Write strobe for the shadow table |
| tbl_addr | input | SW | Table index to write |
| tbl_entry | input | SW | Slot number stored at that index |
| out_valid | output | 1 | Output word present |
| out_start | output | 1 | Output word is output slot 0 |
| out_data | output | DW | Output slot word |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a table write and the frame start that loads the working table. The bench programs every new mapping starting in the frame-start cycle itself, one entry per slot. Its model snapshots the shadow copy before applying that cycle's write. A design that lets the write through early gives wrong words in the next frame.

The second pair is a store into one bank and a read of the other bank at the same slot. This happens on every slot of back-to-back frames. It is judged by a scoreboard that holds the expected permutation for both memory organizations at once, with random mappings, random idle cycles and out-of-range table writes.

// File: rtl/slot_interchanger.sv
module slot_interchanger #(
  parameter int SLOTS = 8,
  parameter int DW = 8,
  parameter bit RANDOM_WRITE = 1'b0,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_valid,
  input  logic          frame_start,
  input  logic [DW-1:0] slot_data,
  input  logic          tbl_we,
  input  logic [SW-1:0] tbl_addr,
  input  logic [SW-1:0] tbl_entry,
  output logic          out_valid,
  output logic          out_start,
  output logic [DW-1:0] out_data
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] cnt;
  logic [1:0] fcnt;
  logic bank;
  logic [SLOTS-1:0][SW-1:0] tbl_sh, tbl_act;
  logic [DW-1:0] mem [2][SLOTS];

  wire boundary = slot_valid & frame_start;
  wire [SW-1:0] slot = frame_start ? '0 : cnt;
  wire wbank = boundary ? ~bank : bank;
  wire [SLOTS-1:0][SW-1:0] tbl_now = boundary ? tbl_sh : tbl_act;
  wire [SW-1:0] map = tbl_now[slot];
  wire [SW-1:0] waddr = RANDOM_WRITE ? map : slot;
  wire [SW-1:0] raddr = RANDOM_WRITE ? slot : map;
  wire live = (fcnt == 2'd2) | (boundary & (fcnt != 2'd0));
  wire cfg_ok = tbl_we & (tbl_addr <= LAST) & (tbl_entry <= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      fcnt <= '0;
      bank <= 1'b0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        tbl_sh[i] <= SW'(i);
        tbl_act[i] <= SW'(i);
      end
    end else begin
      out_valid <= slot_valid & live;
      out_start <= boundary & live;
      if (slot_valid) cnt <= (slot == LAST) ? '0 : slot + 1'b1;
      if (boundary) begin
        bank <= wbank;
        tbl_act <= tbl_sh;
        if (fcnt != 2'd2) fcnt <= fcnt + 1'b1;
      end
      if (cfg_ok) tbl_sh[tbl_addr] <= tbl_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (slot_valid) begin
      mem[wbank][waddr] <= slot_data;
      out_data <= mem[~wbank][raddr];
    end
  end
endmodule

// File: rtl/slot_interchanger_chk.sv
module slot_interchanger_chk #(
  parameter int SLOTS = 8,
  parameter int SW = 3
) (
  input logic clk,
  input logic rst_n,
  input logic slot_valid,
  input logic frame_start,
  input logic out_valid,
  input logic out_start,
  input logic [1:0] fcnt,
  input logic [SLOTS-1:0][SW-1:0] tbl_act
);
  AST_QUIET_BEFORE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == 2'd0) |=> !out_valid); // R2
  AST_VALID_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(slot_valid)); // R7
  AST_START_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && frame_start && fcnt != 2'd0) |=> (out_valid && out_start)); // R3
  AST_START_ONLY_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> $past(slot_valid && frame_start)); // R3
  AST_TABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_valid && frame_start) |=> $stable(tbl_act)); // R6
endmodule

bind slot_interchanger slot_interchanger_chk #(.SLOTS(SLOTS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .frame_start(frame_start),
  .out_valid(out_valid), .out_start(out_start), .fcnt(fcnt), .tbl_act(tbl_act)
);

// File: tb/slot_interchanger_test.sv
module slot_interchanger_test;
  localparam int T = 6;
  localparam int DW = 8;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  logic sv = 0, fs = 0;
  logic [DW-1:0] sd = '0;
  logic we0 = 0, we1 = 0;
  logic [SW-1:0] a0 = '0, e0 = '0, a1 = '0, e1 = '0;
  logic ov0, os0, ov1, os1;
  logic [DW-1:0] od0, od1;

  int checks = 0, errors = 0;
  logic [DW:0] q0[$], q1[$];
  int perm_sh[T], perm_act[T], perm_old[T], np[T];
  logic [DW-1:0] cur[T], prev[T];
  int fcount = 0;
  bit exp_ov = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slot_interchanger #(.SLOTS(T), .DW(DW), .RANDOM_WRITE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .slot_valid(sv), .frame_start(fs), .slot_data(sd),
    .tbl_we(we0), .tbl_addr(a0), .tbl_entry(e0),
    .out_valid(ov0), .out_start(os0), .out_data(od0));

  slot_interchanger #(.SLOTS(T), .DW(DW), .RANDOM_WRITE(1'b1)) uut_rw (
    .clk(clk), .rst_n(rst_n), .slot_valid(sv), .frame_start(fs), .slot_data(sd),
    .tbl_we(we1), .tbl_addr(a1), .tbl_entry(e1),
    .out_valid(ov1), .out_start(os1), .out_data(od1));

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(bit v);
    @(posedge clk);
    exp_ov = v && (fcount >= 2);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ov0 == exp_ov, "R2_R7", "sequential-write out_valid", ov0, exp_ov);
      check(ov1 == exp_ov, "R2_R7", "random-write out_valid", ov1, exp_ov);
      if (ov0) begin
        if (q0.size() == 0) check(0, "R2", "sequential-write unexpected word", od0, -1);
        else begin
          logic [DW:0] e;
          e = q0.pop_front();
          check(os0 == e[DW], "R3", "sequential-write out_start", os0, e[DW]);
          check(od0 == e[DW-1:0], "R4", "sequential-write data", od0, e[DW-1:0]);
        end
      end
      if (ov1) begin
        if (q1.size() == 0) check(0, "R2", "random-write unexpected word", od1, -1);
        else begin
          logic [DW:0] e;
          e = q1.pop_front();
          check(os1 == e[DW], "R3", "random-write out_start", os1, e[DW]);
          check(od1 == e[DW-1:0], "R5", "random-write data", od1, e[DW-1:0]);
        end
      end
    end
  end

  task automatic run_frame(bit newperm, bit gaps, bit oob);
    if (newperm) begin
      for (int i = 0; i < T; i++) np[i] = i;
      for (int i = T - 1; i > 0; i--) begin
        int r, t;
        r = int'($urandom % (i + 1));
        t = np[i]; np[i] = np[r]; np[r] = t;
      end
    end
    for (int s = 0; s < T; s++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        sv = 0; fs = 0; we0 = 0; we1 = 0;
        tick(0);
      end
      sv = 1; fs = (s == 0); sd = DW'($urandom);
      we0 = 0; we1 = 0;
      if (s == 0) begin
        fcount++;
        for (int j = 0; j < T; j++) begin
          prev[j] = cur[j];
          perm_old[j] = perm_act[j];
          perm_act[j] = perm_sh[j];
        end
        if (fcount >= 2)
          for (int j = 0; j < T; j++) begin
            q0.push_back({j == 0, prev[perm_act[j]]});
            q1.push_back({j == 0, prev[perm_old[j]]});
          end
      end
      cur[s] = sd;
      if (newperm) begin
        // R6: writes start in the frame-start cycle itself
        we0 = 1; a0 = SW'(s); e0 = SW'(np[s]);
        we1 = 1; a1 = SW'(np[s]); e1 = SW'(s);
        perm_sh[s] = np[s];
      end else if (oob) begin
        // R8: entry 7 and index 7 are beyond SLOTS-1 = 5
        we0 = 1; a0 = SW'(s % T); e0 = 3'd7;
        we1 = 1; a1 = 3'd7; e1 = SW'(s % T);
      end
      tick(1);
    end
    sv = 0; fs = 0; we0 = 0; we1 = 0;
  endtask

  initial begin
    for (int i = 0; i < T; i++) begin
      perm_sh[i] = i; perm_act[i] = i; perm_old[i] = i; cur[i] = '0;
    end
    repeat (3) tick(0);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(ov0 == 0 && os0 == 0, "R1", "reset outputs", {ov0, os0}, 0);
    check(ov1 == 0 && os1 == 0, "R1", "reset outputs rw", {ov1, os1}, 0);
    #1;
    // R9: slots arriving before any frame start wrap the counter without output
    for (int s = 0; s < T + 2; s++) begin
      sv = 1; fs = 0; sd = DW'(s);
      tick(1);
    end
    sv = 0;
    // R1: identity table carries frames 0 to 1 unchanged
    run_frame(0, 0, 0);
    check(q0.size() == 0, "R2", "no output during first frame", q0.size(), 0);
    for (int f = 1; f < 14; f++)
      run_frame(f % 2 == 0, f % 3 == 1, (f % 4 == 3) && (f % 2 != 0));
    run_frame(0, 0, 0);
    tick(0);
    tick(0);
    check(q0.size() == 0, "R3", "sequential-write words left undelivered", q0.size(), 0);
    check(q1.size() == 0, "R3", "random-write words left undelivered", q1.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule